// File: doc/BRIEF.md
# Sign-Correlating Coefficient Update Bank

This block computes the tap coefficients of a nine-tap adaptive transversal equalizer with a zero-forcing rule. Every clock it takes one signed error word and the sign of the current decision. A short shift register holds the last eight decision signs. For each tap the error is negated or passed through according to the sign of the decision that belongs to that tap. The bank never forms a full product: the negation is a bitwise inversion of the error plus a carry injected at the least significant position.

Each tap keeps a running total in redundant form, as separate sum and carry words, updated by one 3:2 compressor stage. No carry ripples during accumulation, so the per-cycle path stays short whatever the accumulator width. Once every 128 clocks a ripple adder resolves the two words for every tap. The upper byte of the resolved value is then registered onto the coefficient bus, where it stays for the next 128 clocks. A one-cycle pulse marks each load.

Top module: `zf_coef_update`

## Requirements
- R1: While rst_ni is low, coef_o and coef_load_o are all zero, every accumulator is zero and every stored decision sign is positive (0).
- R2: dec_neg_i = 0 means a non-negative decision. For such a tap the sample adds err_i (8-bit two's complement) to its accumulator; for dec_neg_i = 1 it adds the two's complement negation of err_i.
- R3: Tap k (0 to 8) uses the decision sign from k samples before the current one; tap 0 uses the current dec_neg_i. Signs from before the end of reset count as positive.
- R4: Each accumulator is 16 bits wide and keeps a running total modulo 2^16. Only reset clears it; a coefficient load does not.
- R5: A coefficient load happens at the 128th rising edge after reset release, and every 128 edges after that. coef_load_o is high for exactly the cycle that follows each load edge. coef_o changes only at load edges.
- R6: At a load edge, each tap's coefficient becomes bits 15:8 of its accumulator total, counting the sample taken at that same edge.
- R7: coef_o packs tap k in bits [8k+7:8k].
- R8: An error of -128 with dec_neg_i = 1 contributes +128, not -128.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; one sample per rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| err_i | input | 8 | Signed error word of the current sample |
| dec_neg_i | input | 1 | Sign of the current decision, 1 = negative |
| coef_o | output | 72 | Nine 8-bit two's complement coefficients, tap k at [8k+7:8k] |
| coef_load_o | output | 1 | High for one cycle after each coefficient load |

## Verification
An internal fault stays hidden at the ports until the next load. A corrupted sum or carry bit, a lost injected carry or a misaligned sign delay shows up only as a wrong coefficient byte, up to 128 cycles later. Small errors show only once enough samples have piled up to move bit 8. The stimulus therefore uses windows of large magnitude, the extreme negative error and enough windows to wrap the accumulators. Every tap is compared at every load, and the bus is checked in each cycle between loads to show that it holds.

// File: rtl/zf_pkg.sv
package zf_pkg;
  localparam int unsigned NUM_TAPS_DEF = 9;
  localparam int unsigned ERR_W_DEF    = 8;
  localparam int unsigned ACC_W_DEF    = 16;
  localparam int unsigned COEF_W_DEF   = 8;
  localparam int unsigned WIN_LOG2_DEF = 7;
endpackage

// File: rtl/zf_sign_delay.sv
module zf_sign_delay #(
  parameter int unsigned NUM_TAPS = zf_pkg::NUM_TAPS_DEF
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                dec_neg_i,
  output logic [NUM_TAPS-1:0] tap_neg_o
);
  localparam int unsigned DEPTH = (NUM_TAPS > 1) ? NUM_TAPS - 1 : 1;

  logic [DEPTH-1:0] hist_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hist_q <= '0;
    else if (DEPTH == 1) hist_q[0] <= dec_neg_i;
    else hist_q <= {hist_q[DEPTH-2:0], dec_neg_i};
  end

  assign tap_neg_o[0] = dec_neg_i;
  for (genvar k = 1; k < NUM_TAPS; k++) begin : g_tap
    assign tap_neg_o[k] = hist_q[k-1];
  end

  logic run_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= 1'b0;
    else run_q <= 1'b1;
  end

  for (genvar k = 1; k < NUM_TAPS; k++) begin : g_chk
    AST_SIGN_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      run_q |-> tap_neg_o[k] == $past(tap_neg_o[k-1])); // R3
  end
endmodule

// File: rtl/zf_win_timer.sv
module zf_win_timer #(
  parameter int unsigned WIN_LOG2 = zf_pkg::WIN_LOG2_DEF
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic load_o,
  output logic load_q_o
);
  localparam logic [WIN_LOG2-1:0] WIN_LAST = '1;

  logic [WIN_LOG2-1:0] cnt_q;
  logic                load_q;

  assign load_o   = (cnt_q == WIN_LAST);
  assign load_q_o = load_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      load_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
      load_q <= load_o;
    end
  end

  AST_LOAD_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_q |=> !load_q); // R5
  AST_LOAD_PHASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_q |-> cnt_q == '0); // R5
endmodule

// File: rtl/zf_csa_tap.sv
module zf_csa_tap #(
  parameter int unsigned ERR_W  = zf_pkg::ERR_W_DEF,
  parameter int unsigned ACC_W  = zf_pkg::ACC_W_DEF,
  parameter int unsigned COEF_W = zf_pkg::COEF_W_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ERR_W-1:0]  err_i,
  input  logic              neg_i,
  input  logic              load_i,
  output logic [COEF_W-1:0] coef_o
);
  localparam int unsigned EXT_W = ACC_W - ERR_W;

  logic [ACC_W-1:0]  sum_q, car_q, sum_d, car_d, add_in, maj, merged;
  logic [ERR_W-1:0]  err_x;
  logic [COEF_W-1:0] coef_q;

  // ones' complement by XOR; the +1 rides in the free carry LSB
  assign err_x  = err_i ^ {ERR_W{neg_i}};
  assign add_in = {{EXT_W{err_x[ERR_W-1]}}, err_x};
  assign sum_d  = sum_q ^ car_q ^ add_in;
  assign maj    = (sum_q & car_q) | (sum_q & add_in) | (car_q & add_in);
  assign car_d  = {maj[ACC_W-2:0], neg_i};
  assign merged = sum_d + car_d;
  assign coef_o = coef_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sum_q  <= '0;
      car_q  <= '0;
      coef_q <= '0;
    end else begin
      sum_q <= sum_d;
      car_q <= car_d;
      if (load_i) coef_q <= merged[ACC_W-1 -: COEF_W];
    end
  end

  logic             run_q;
  logic [ACC_W-1:0] tot, term, ext_err;
  assign tot     = sum_q + car_q;
  assign ext_err = {{EXT_W{err_i[ERR_W-1]}}, err_i};
  assign term    = neg_i ? (ACC_W'(0) - ext_err) : ext_err;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= 1'b0;
    else run_q <= 1'b1;
  end

  AST_CSA_TOTAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> tot == $past(tot) + $past(term)); // R2
  AST_COEF_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && !$past(load_i)) |-> $stable(coef_q)); // R5
endmodule

// File: rtl/zf_coef_update.sv
module zf_coef_update #(
  parameter int unsigned NUM_TAPS = zf_pkg::NUM_TAPS_DEF,
  parameter int unsigned ERR_W    = zf_pkg::ERR_W_DEF,
  parameter int unsigned ACC_W    = zf_pkg::ACC_W_DEF,
  parameter int unsigned COEF_W   = zf_pkg::COEF_W_DEF,
  parameter int unsigned WIN_LOG2 = zf_pkg::WIN_LOG2_DEF
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [ERR_W-1:0]           err_i,
  input  logic                       dec_neg_i,
  output logic [NUM_TAPS*COEF_W-1:0] coef_o,
  output logic                       coef_load_o
);
  logic [NUM_TAPS-1:0] tap_neg;
  logic                load;

  zf_sign_delay #(.NUM_TAPS(NUM_TAPS)) u_delay (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .dec_neg_i(dec_neg_i),
    .tap_neg_o(tap_neg)
  );

  zf_win_timer #(.WIN_LOG2(WIN_LOG2)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_o  (load),
    .load_q_o(coef_load_o)
  );

  for (genvar k = 0; k < NUM_TAPS; k++) begin : g_tap
    zf_csa_tap #(.ERR_W(ERR_W), .ACC_W(ACC_W), .COEF_W(COEF_W)) u_tap (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .err_i (err_i),
      .neg_i (tap_neg[k]),
      .load_i(load),
      .coef_o(coef_o[k*COEF_W +: COEF_W])
    );
  end

  AST_RESET_CLEAR: assert property (@(posedge clk_i)
    !rst_ni |-> (coef_o == '0 && !coef_load_o)); // R1
endmodule

// File: tb/zf_coef_update_bench.sv
`timescale 1ns/1ps
module zf_coef_update_bench;
  localparam int NT = 9;
  localparam int WIN = 128;
  localparam int NWIN = 11;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  err = '0;
  logic        neg = 1'b0;
  logic [71:0] coef;
  logic        load;

  int tests = 0, fails = 0;
  bit done = 0;
  int acc [NT];
  bit hist [NT];
  int exp_coef [NT];
  logic [15:0] lfsr = 16'hACE1;

  always #2.5 clk = ~clk;

  zf_coef_update u_zf_coef_update (
    .clk_i(clk), .rst_ni(rst_ni), .err_i(err), .dec_neg_i(neg),
    .coef_o(coef), .coef_load_o(load)
  );

  task automatic chk(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic pick(int n);
    int w, i;
    w = n / WIN; i = n % WIN;
    case (w)
      0: begin err = 8'd5; neg = 1'b0; end
      1: begin err = 8'(i - 64); neg = i[0]; end
      2: begin err = 8'h80; neg = 1'b1; end          // R8 extreme
      3, 4, 5, 6: begin err = 8'd127; neg = 1'b0; end // R4 wrap
      7, 8, 9: begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        err = lfsr[7:0]; neg = lfsr[11];
      end
      default: begin err = 8'(2 * i); neg = i[3]; end
    endcase
  endtask

  initial begin
    for (int k = 0; k < NT; k++) begin acc[k] = 0; hist[k] = 0; exp_coef[k] = 0; end
    repeat (3) @(posedge clk);
    #1;
    chk("R1 coef in reset", int'(coef != '0), 0);
    chk("R1 load in reset", int'(load), 0);
    @(negedge clk);
    rst_ni = 1'b1;
    pick(0);
    for (int n = 0; n < NWIN * WIN; n++) begin
      bit ld;
      @(posedge clk);
      for (int k = 0; k < NT; k++) begin
        bit s;
        int t;
        s = (k == 0) ? neg : hist[k-1];                // R3
        t = s ? -int'($signed(err)) : int'($signed(err)); // R2 R8
        acc[k] = (acc[k] + t) & 32'hFFFF;               // R4
      end
      for (int k = NT - 1; k > 0; k--) hist[k] = hist[k-1];
      hist[0] = neg;
      ld = (n % WIN) == WIN - 1;
      if (ld) for (int k = 0; k < NT; k++) exp_coef[k] = acc[k] >> 8;
      @(negedge clk);
      chk("R5 load pulse", int'(load), int'(ld));
      for (int k = 0; k < NT; k++)
        chk(ld ? "R6 R7 coef at load" : "R5 coef hold",
            int'(coef[k*8 +: 8]), exp_coef[k]);
      if (n + 1 < NWIN * WIN) pick(n + 1);
    end
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule